// File: doc/BRIEF.md
# Segment Access Limit and Rights Checker

This block checks one memory access against a cached 64-bit application segment descriptor. It rebuilds the 32-bit base and the 20-bit raw limit from the fields scattered through the descriptor. It scales the limit by the granularity flag and applies either expand-up or expand-down bounds. It also checks the access kind against the segment type. It returns the linear address and a two-bit fault code.

A requester presents the descriptor, the offset, an access size and an access kind together with a one-cycle valid strobe. Exactly one clock later the block raises a one-cycle done pulse. On that pulse the result registers hold the linear address (base plus offset, modulo 2^32) and the fault code. Both registers keep their values until the next strobe.

Top module: `seg_limit_checker`

## Requirements
- R1: After synchronous reset, `rsp_done` is 0, `rsp_fault` is 0 and `rsp_lin` is 0.
- R2: `rsp_done` is 1 in the cycle after `req_valid` and only then. The result registers change only when a strobe is taken, so inputs that change while `req_valid` is low leave `rsp_fault` and `rsp_lin` unchanged.
- R3: The raw limit is descriptor bits [51:48] joined above bits [15:0]. With granularity bit 55 at 0, the raw limit is zero-extended to give the effective limit. With bit 55 at 1, the raw limit is shifted left by 12 and the low 12 bits are filled with ones.
- R4: The base is bits [63:56], then [39:32], then [31:16], from most to least significant. `rsp_lin` equals base plus offset modulo 2^32, and the granularity bit has no effect on it.
- R5: A segment is expand-up when type bit 43 is 1 (code) or when type bit 42 is 0. For an expand-up segment, an access of 2^`req_size` bytes passes the bounds check only if its last byte, offset + 2^size − 1, is at most the effective limit.
- R6: A segment is expand-down when bit 43 is 0 and bit 42 is 1. For an expand-down segment, the first byte must lie above the effective limit. The last byte must be at most 0xFFFFFFFF when bit 54 is 1, and at most 0xFFFF when bit 54 is 0.
- R7: An access whose last byte would pass 0xFFFFFFFF gives a limit fault, for every segment kind.
- R8: For a data segment (bit 43 = 0), a read is always allowed. A write needs writable bit 41 set. A fetch always gives a rights fault.
- R9: For a code segment (bit 43 = 1), a fetch is always allowed. A read needs readable bit 41 set. A write always gives a rights fault.
- R10: The fault codes are 0 for none, 1 for not-present, 2 for limit and 3 for rights. Access kinds are 0 for read, 1 for write, and 2 or 3 for fetch. A present bit (bit 47) of 0 gives code 1 regardless of anything else. Otherwise a rights fault (code 3) takes precedence over a limit fault (code 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Strobe that samples the request |
| req_desc | input | 64 | Cached segment descriptor |
| req_offset | input | 32 | Byte offset of the first byte accessed |
| req_size | input | 2 | Access size, 2^size bytes |
| req_kind | input | 2 | 0 read, 1 write, 2 or 3 fetch |
| rsp_done | output | 1 | One-cycle pulse, one clock after the strobe |
| rsp_fault | output | 2 | 0 none, 1 not-present, 2 limit, 3 rights |
| rsp_lin | output | 32 | Linear address, base plus offset |

## Verification
A wrong limit scale or a misplaced bound shows up as a wrong limit code on the very next done pulse. It is visible only when the offset sits at the edge of the limit, so stimulus concentrates offsets a few bytes around the effective limit and around the 64 KiB and 4 GiB tops. A mis-assembled base changes `rsp_lin` on the same pulse for almost any descriptor. A broken capture enable shows as results that drift during idle cycles. A wrong priority shows only on descriptors that carry more than one fault at once, so directed cases combine them.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;
  parameter int ADDR_W    = 32;
  parameter int DESC_W    = 64;
  parameter int RAW_LIM_W = 20;
  parameter int SZ_W      = 2;
  parameter int LOW_TOP_W = 16;

  typedef enum logic [1:0] {
    ACC_READ      = 2'd0,
    ACC_WRITE     = 2'd1,
    ACC_FETCH     = 2'd2,
    ACC_FETCH_ALT = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE        = 2'd0,
    FLT_NOT_PRESENT = 2'd1,
    FLT_LIMIT       = 2'd2,
    FLT_RIGHTS      = 2'd3
  } fault_e;

  typedef struct packed {
    logic [ADDR_W-1:0]    base;
    logic [RAW_LIM_W-1:0] raw_lim;
    logic [3:0]           seg_type;
    logic                 present;
    logic                 big;
    logic                 gran;
  } desc_fields_t;
endpackage

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack
  import seg_chk_pkg::*;
(
  input  logic [DESC_W-1:0] desc,
  output desc_fields_t      fields,
  output logic [ADDR_W-1:0] eff_limit
);
  localparam int GRAN_SHIFT = ADDR_W - RAW_LIM_W;

  always_comb begin
    fields.raw_lim  = {desc[51:48], desc[15:0]};
    fields.base     = {desc[63:56], desc[39:32], desc[31:16]};
    fields.seg_type = desc[43:40];
    fields.present  = desc[47];
    fields.big      = desc[54];
    fields.gran     = desc[55];
  end

  always_comb begin
    if (fields.gran)
      eff_limit = {fields.raw_lim, {GRAN_SHIFT{1'b1}}};
    else
      eff_limit = {{GRAN_SHIFT{1'b0}}, fields.raw_lim};
  end
endmodule

// File: rtl/seg_bound_check.sv
module seg_bound_check
  import seg_chk_pkg::*;
(
  input  logic [ADDR_W-1:0] offset,
  input  logic [SZ_W-1:0]   size,
  input  logic [ADDR_W-1:0] limit,
  input  logic              exp_down,
  input  logic              big,
  output logic              in_bounds
);
  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] span_ext;
  logic [EXT_W-1:0] first_ext;
  logic [EXT_W-1:0] last_ext;
  logic [EXT_W-1:0] lim_ext;
  logic [EXT_W-1:0] top_ext;
  logic             up_ok;
  logic             dn_ok;

  always_comb begin
    span_ext  = ({{(EXT_W-1){1'b0}}, 1'b1} << size) - {{(EXT_W-1){1'b0}}, 1'b1};
    first_ext = {1'b0, offset};
    last_ext  = first_ext + span_ext;
    lim_ext   = {1'b0, limit};
    top_ext   = big ? {1'b0, {ADDR_W{1'b1}}}
                    : {{(EXT_W-LOW_TOP_W){1'b0}}, {LOW_TOP_W{1'b1}}};
    up_ok     = (last_ext <= lim_ext);
    dn_ok     = (first_ext > lim_ext) && (last_ext <= top_ext);
    in_bounds = exp_down ? dn_ok : up_ok;
  end
endmodule

// File: rtl/seg_rights_check.sv
module seg_rights_check
  import seg_chk_pkg::*;
(
  input  logic [3:0] seg_type,
  input  acc_kind_e  kind,
  output logic       allowed
);
  logic is_code;
  logic perm_bit;

  always_comb begin
    is_code  = seg_type[3];
    perm_bit = seg_type[1];
    unique case (kind)
      ACC_READ:  allowed = !is_code || perm_bit;
      ACC_WRITE: allowed = !is_code && perm_bit;
      default:   allowed = is_code;
    endcase
  end
endmodule

// File: rtl/seg_limit_checker.sv
module seg_limit_checker
  import seg_chk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [DESC_W-1:0] req_desc,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [SZ_W-1:0]   req_size,
  input  logic [1:0]        req_kind,
  output logic              rsp_done,
  output logic [1:0]        rsp_fault,
  output logic [ADDR_W-1:0] rsp_lin
);
  desc_fields_t      fld;
  logic [ADDR_W-1:0] eff_limit;
  logic              exp_down;
  logic              bounds_ok;
  logic              rights_ok;
  fault_e            fault_nxt;
  acc_kind_e         kind_e;

  assign kind_e = acc_kind_e'(req_kind);

  seg_desc_unpack u_unpack (
    .desc      (req_desc),
    .fields    (fld),
    .eff_limit (eff_limit)
  );

  assign exp_down = !fld.seg_type[3] && fld.seg_type[2];

  seg_bound_check u_bounds (
    .offset    (req_offset),
    .size      (req_size),
    .limit     (eff_limit),
    .exp_down  (exp_down),
    .big       (fld.big),
    .in_bounds (bounds_ok)
  );

  seg_rights_check u_rights (
    .seg_type (fld.seg_type),
    .kind     (kind_e),
    .allowed  (rights_ok)
  );

  always_comb begin
    if (!fld.present)    fault_nxt = FLT_NOT_PRESENT;
    else if (!rights_ok) fault_nxt = FLT_RIGHTS;
    else if (!bounds_ok) fault_nxt = FLT_LIMIT;
    else                 fault_nxt = FLT_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_done  <= 1'b0;
      rsp_fault <= FLT_NONE;
      rsp_lin   <= '0;
    end else begin
      rsp_done <= req_valid;
      if (req_valid) begin
        rsp_fault <= fault_nxt;
        rsp_lin   <= fld.base + req_offset;
      end
    end
  end

  // R2: a strobe is answered on the next cycle
  a_r2_done_after_valid: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_done);

  // R2: no done pulse without a strobe
  a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_done);

  // R4: linear address from the raw descriptor bit fields
  a_r4_linear_sum: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_lin == $past({req_desc[63:56], req_desc[39:32], req_desc[31:16]} + req_offset));

  // R10: absence dominates every other fault
  a_r10_not_present_first: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_desc[47]) |=> rsp_fault == FLT_NOT_PRESENT);

  // R9: writes into code segments never succeed
  a_r9_code_write_blocked: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_desc[47] && req_desc[43] && req_kind == ACC_WRITE) |=> rsp_fault == FLT_RIGHTS);

  // R8: fetching from a data segment never succeeds
  a_r8_data_fetch_blocked: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_desc[47] && !req_desc[43] && req_kind[1]) |=> rsp_fault == FLT_RIGHTS);

  // R2: results hold while idle
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!req_valid && !$past(rst)) |=> ($stable(rsp_fault) && $stable(rsp_lin)));
endmodule

// File: tb/seg_limit_checker_tb_top.sv
module seg_limit_checker_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [63:0] req_desc;
  logic [31:0] req_offset;
  logic [1:0]  req_size;
  logic [1:0]  req_kind;
  logic        rsp_done;
  logic [1:0]  rsp_fault;
  logic [31:0] rsp_lin;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  seg_limit_checker dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_desc(req_desc),
    .req_offset(req_offset), .req_size(req_size), .req_kind(req_kind),
    .rsp_done(rsp_done), .rsp_fault(rsp_fault), .rsp_lin(rsp_lin)
  );

  function automatic logic [63:0] mk_desc(logic [31:0] base, logic [19:0] lim,
                                          logic [3:0] typ, logic p, logic b, logic g);
    return {base[31:24], g, b, 2'b00, lim[19:16], p, 2'b00, 1'b1, typ,
            base[23:0], lim[15:0]};
  endfunction

  function automatic logic [31:0] ref_limit(logic [63:0] d);
    logic [19:0] raw;
    raw = {d[51:48], d[15:0]};
    return d[55] ? ((32'(raw) << 12) | 32'hFFF) : 32'(raw);
  endfunction

  function automatic logic [31:0] ref_lin(logic [63:0] d, logic [31:0] off);
    logic [31:0] b;
    b = {d[63:56], d[39:32], d[31:16]};
    return b + off;
  endfunction

  function automatic logic [1:0] ref_fault(logic [63:0] d, logic [31:0] off,
                                           logic [1:0] sz, logic [1:0] kd);
    logic        code, perm, ok_r, ok_b;
    logic [32:0] lo, hi, lim, top;
    code = d[43];
    perm = d[41];
    if (!d[47]) return 2'd1;
    case (kd)
      2'd0:    ok_r = code ? perm : 1'b1;
      2'd1:    ok_r = code ? 1'b0 : perm;
      default: ok_r = code;
    endcase
    if (!ok_r) return 2'd3;
    lo  = {1'b0, off};
    hi  = lo + 33'((1 << sz) - 1);
    lim = {1'b0, ref_limit(d)};
    top = d[54] ? 33'h0_FFFF_FFFF : 33'h0_0000_FFFF;
    if (!code && d[42]) ok_b = (lo > lim) && (hi <= top);
    else                ok_b = (hi <= lim);
    return ok_b ? 2'd0 : 2'd2;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_for(logic [63:0] d, logic [1:0] f, logic [1:0] kd);
    if (f == 2'd1) return "R10 fault";
    if (f == 2'd3) return d[43] ? "R9 fault" : "R8 fault";
    if (!d[43] && d[42]) return "R6 fault";
    return "R5 fault";
  endfunction

  task automatic access(logic [63:0] d, logic [31:0] off, logic [1:0] sz, logic [1:0] kd);
    logic [1:0]  ef;
    logic [31:0] el;
    ef = ref_fault(d, off, sz, kd);
    el = ref_lin(d, off);
    req_valid = 1'b1; req_desc = d; req_offset = off; req_size = sz; req_kind = kd;
    @(negedge clk);
    req_valid = 1'b0;
    req_desc = ~d; req_offset = ~off; req_size = ~sz; req_kind = ~kd;
    chk("R2 done", 32'(rsp_done), 32'd1);
    chk(tag_for(d, ef, kd), 32'(rsp_fault), 32'(ef));
    chk("R4 linear", rsp_lin, el);
    @(negedge clk);
    chk("R2 idle done", 32'(rsp_done), 32'd0);
    chk("R2 hold fault", 32'(rsp_fault), 32'(ef));
    chk("R2 hold linear", rsp_lin, el);
  endtask

  task automatic expect_fault(string tag, logic [63:0] d, logic [31:0] off,
                              logic [1:0] sz, logic [1:0] kd, logic [1:0] want);
    req_valid = 1'b1; req_desc = d; req_offset = off; req_size = sz; req_kind = kd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, 32'(rsp_fault), 32'(want));
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    logic [31:0] lim, off;
    void'($urandom(32'd20240611));
    rst = 1'b1; req_valid = 1'b0; req_desc = '0; req_offset = '0;
    req_size = '0; req_kind = '0;
    repeat (3) @(negedge clk);
    chk("R1 done", 32'(rsp_done), 32'd0);
    chk("R1 fault", 32'(rsp_fault), 32'd0);
    chk("R1 linear", rsp_lin, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // R3 granularity scaling
    d = mk_desc(32'h0, 20'hFFFFF, 4'b0010, 1, 1, 1);
    expect_fault("R3 g1 top", d, 32'hFFFF_FFFC, 2'd2, 2'd0, 2'd0);
    d = mk_desc(32'h0, 20'hFFFFF, 4'b0010, 1, 1, 0);
    expect_fault("R3 g0 edge", d, 32'h000F_FFFF, 2'd0, 2'd0, 2'd0);
    expect_fault("R3 g0 past", d, 32'h0010_0000, 2'd0, 2'd0, 2'd2);
    d = mk_desc(32'h0, 20'h00001, 4'b0010, 1, 1, 1);
    expect_fault("R3 g1 unit edge", d, 32'h0000_1FFF, 2'd0, 2'd0, 2'd0);
    expect_fault("R3 g1 unit past", d, 32'h0000_2000, 2'd0, 2'd0, 2'd2);

    // R5 multi-byte straddle
    d = mk_desc(32'h1000, 20'h00100, 4'b0010, 1, 1, 0);
    expect_fault("R5 two bytes fit", d, 32'hFF, 2'd1, 2'd0, 2'd0);
    expect_fault("R5 four bytes cross", d, 32'hFF, 2'd2, 2'd0, 2'd2);

    // R6 expand-down with both upper bounds
    d = mk_desc(32'h0, 20'h00FFF, 4'b0110, 1, 0, 0);
    expect_fault("R6 at limit", d, 32'h0FFF, 2'd0, 2'd0, 2'd2);
    expect_fault("R6 above limit", d, 32'h1000, 2'd0, 2'd0, 2'd0);
    expect_fault("R6 small top fit", d, 32'hFFFE, 2'd1, 2'd1, 2'd0);
    expect_fault("R6 small top cross", d, 32'hFFFE, 2'd2, 2'd1, 2'd2);
    d = mk_desc(32'h0, 20'h00FFF, 4'b0110, 1, 1, 0);
    expect_fault("R6 big top above 64K", d, 32'h0001_0000, 2'd0, 2'd0, 2'd0);
    expect_fault("R6 big top last dword", d, 32'hFFFF_FFFC, 2'd2, 2'd0, 2'd0);
    expect_fault("R7 expand-down wrap", d, 32'hFFFF_FFFE, 2'd2, 2'd0, 2'd2);
    d = mk_desc(32'h0, 20'hFFFFF, 4'b1010, 1, 1, 1);
    expect_fault("R7 expand-up wrap", d, 32'hFFFF_FFFE, 2'd2, 2'd2, 2'd2);

    // R8, R9 rights
    d = mk_desc(32'h0, 20'hFFFFF, 4'b0000, 1, 1, 0);
    expect_fault("R8 read-only write", d, 32'h10, 2'd0, 2'd1, 2'd3);
    expect_fault("R8 read-only read", d, 32'h10, 2'd0, 2'd0, 2'd0);
    expect_fault("R8 data fetch", d, 32'h10, 2'd0, 2'd2, 2'd3);
    expect_fault("R8 data fetch alt", d, 32'h10, 2'd0, 2'd3, 2'd3);
    d = mk_desc(32'h0, 20'hFFFFF, 4'b1000, 1, 1, 0);
    expect_fault("R9 exec-only read", d, 32'h10, 2'd0, 2'd0, 2'd3);
    expect_fault("R9 exec-only fetch", d, 32'h10, 2'd0, 2'd2, 2'd0);
    d = mk_desc(32'h0, 20'hFFFFF, 4'b1010, 1, 1, 0);
    expect_fault("R9 readable code read", d, 32'h10, 2'd0, 2'd0, 2'd0);
    expect_fault("R9 readable code write", d, 32'h10, 2'd0, 2'd1, 2'd3);

    // R10 priority
    d = mk_desc(32'h0, 20'h00010, 4'b1010, 0, 1, 0);
    expect_fault("R10 absent beats all", d, 32'h5000, 2'd0, 2'd1, 2'd1);
    d = mk_desc(32'h0, 20'h00010, 4'b1010, 1, 1, 0);
    expect_fault("R10 rights beats limit", d, 32'h5000, 2'd0, 2'd1, 2'd3);

    // R4 base wrap, granularity has no effect on base
    access(mk_desc(32'hFFFF_FF00, 20'hFFFFF, 4'b0010, 1, 1, 0), 32'h200, 2'd0, 2'd0);
    access(mk_desc(32'hFFFF_FF00, 20'hFFFFF, 4'b0010, 1, 1, 1), 32'h200, 2'd0, 2'd0);
    access(mk_desc(32'h1234_5678, 20'h00ABC, 4'b0010, 1, 0, 0), 32'h10, 2'd0, 2'd0);

    // random stimulus, offsets clustered at the edges
    for (int i = 0; i < 1500; i++) begin
      d = {$urandom, $urandom};
      d[47] = ($urandom % 8) != 0;
      lim = ref_limit(d);
      case ($urandom % 4)
        0:       off = lim + 32'($urandom % 9) - 32'd4;
        1:       off = 32'hFFFF + 32'($urandom % 9) - 32'd4;
        2:       off = 32'hFFFF_FFF8 + 32'($urandom % 8);
        default: off = $urandom;
      endcase
      access(d, off, 2'($urandom), 2'($urandom % 3));
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule